// File: doc/BRIEF.md
# Dual-Bank Operand Memory Access Unit

This block moves operands between a register-side datapath and two 32-bit data memory banks, called X and Y, which it holds internally. It also holds eight address registers. Each request names a reference kind, one or two address registers and their update modes, an offset value, read/write directions and write data. The unit forms the effective addresses, checks that the request is legal, issues the bank commands, writes the post-updated addresses back, and returns read data on two register-side lanes (A and B).

The reference kinds are as follows. A single word in X uses lane A. A single word in Y uses lane A. A long word applies one address to both banks: the X word is the high half and travels on lane A, and the Y word is the low half and travels on lane B. The register side can form the long word from a mid:low register pair or from one double-precision register. A dual access reaches both banks in the same cycle. It comes in two forms. The independent form takes two address registers from opposite groups, sends them to opposite banks, and gives each operand its own direction. The common form takes one address register, drives the same address to both banks, and uses a single direction.

Top module: `oma_unit`

## Requirements
- R1: Reference kind code 0 accesses only X and code 1 accesses only Y. Both use the address of register `sel_a`, the direction `wr_a` and the data lane A (`wdata_a`, `rd_a`).
- R2: Reference kind code 2 (long word) drives the address of `sel_a` to both banks. X takes `wdata_a` and returns on `rd_a`, which is the high half. Y takes `wdata_b` and returns on `rd_b`, which is the low half.
- R3: Reference kind code 3 (independent dual) sends operand A to bank `bank_a` (0 = X, 1 = Y) with direction `wr_a` and lane A. It sends operand B to the other bank with direction `wr_b` and lane B. One bank may read while the other writes.
- R4: A kind 3 request is illegal when `sel_a` and `sel_b` come from the same group, or when `bank_a` equals `bank_b`. The group is the top select bit: registers 0–3 versus 4–7.
- R5: A kind 3 request is also illegal when either update mode is above code 3. The allowed codes are 0 none, 1 post +1, 2 post −1 and 3 post +offset.
- R6: Reference kind code 4 (common dual) drives one address to both banks with the single direction `wr_a`. X uses lane A and Y uses lane B. It accepts all update modes 0–6. Reference kinds 5–7 are illegal, and mode 7 is illegal for every kind.
- R7: The update modes are: 0 uses R with no change; 1, 2, 3 and 4 use R and then set R to R+1, R−1, R+offset or R−offset; 5 uses R+offset with no change; 6 uses R−1 and sets R to R−1. Arithmetic wraps modulo the bank depth.
- R8: Updated address values take effect for the next request. In kind 3, both registers are updated in the same cycle.
- R9: Bank commands (`x_en`/`y_en`, address, write enable, write data) appear on the clock edge that follows the request. Read data and the per-lane `rd_vld` bits (bit 0 = lane A, bit 1 = lane B) appear one edge later. `rd_vld` is zero when no read was issued.
- R10: An illegal request raises `err` in the same cycle the commands would have appeared. It enables neither bank, changes no address register and writes no memory.
- R11: After reset, and in any cycle that follows a cycle without `req_valid`, both bank enables and `err` are low. All address registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| ref_kind | input | 3 | Reference kind code (0–4 legal) |
| sel_a | input | 3 | Address register for operand A |
| sel_b | input | 3 | Address register for operand B (kind 3 only) |
| upd_a | input | 3 | Update mode for operand A |
| upd_b | input | 3 | Update mode for operand B |
| offs | input | 6 | Offset value for modes 3, 4 and 5 |
| bank_a | input | 1 | Kind 3: bank of operand A (0 = X, 1 = Y) |
| bank_b | input | 1 | Kind 3: bank of operand B |
| wr_a | input | 1 | Direction of operand A, or common direction (1 = write) |
| wr_b | input | 1 | Direction of operand B (kind 3) |
| wdata_a | input | 32 | Lane A write data |
| wdata_b | input | 32 | Lane B write data |
| x_addr | output | 6 | X bank address |
| x_en | output | 1 | X bank enable |
| x_we | output | 1 | X bank write enable |
| x_wdata | output | 32 | X bank write data |
| y_addr | output | 6 | Y bank address |
| y_en | output | 1 | Y bank enable |
| y_we | output | 1 | Y bank write enable |
| y_wdata | output | 32 | Y bank write data |
| rd_a | output | 32 | Lane A read data |
| rd_b | output | 32 | Lane B read data |
| rd_vld | output | 2 | Read data valid per lane |
| err | output | 1 | Illegal request flag |

## Verification
Each request is presented for exactly one clock edge. The bank commands and `err` are sampled at the falling edge after that edge. Read data and `rd_vld` are sampled one full cycle later, at the falling edge after the second edge. At that same point the bench confirms that both enables have dropped, because the request was withdrawn. The bench keeps its own address registers and bank contents, and computes every expected address and data word from the update-mode arithmetic. Address-register updates are observed through the address of the next request that uses the same register, so each update is checked one request later.

// File: rtl/oma_pkg.sv
package oma_pkg;
  // reference kind codes
  localparam logic [2:0] RK_XWORD  = 3'd0;
  localparam logic [2:0] RK_YWORD  = 3'd1;
  localparam logic [2:0] RK_LONG   = 3'd2;
  localparam logic [2:0] RK_DUAL   = 3'd3;
  localparam logic [2:0] RK_COMMON = 3'd4;

  // address update mode codes
  localparam logic [2:0] UM_NONE   = 3'd0;
  localparam logic [2:0] UM_INC    = 3'd1;
  localparam logic [2:0] UM_DEC    = 3'd2;
  localparam logic [2:0] UM_ADDN   = 3'd3;
  localparam logic [2:0] UM_SUBN   = 3'd4;
  localparam logic [2:0] UM_INDEX  = 3'd5;
  localparam logic [2:0] UM_PREDEC = 3'd6;
  localparam logic [2:0] UM_BAD    = 3'd7;

  // highest mode code allowed in the independent dual form
  localparam logic [2:0] UM_DUAL_MAX = UM_ADDN;
endpackage

// File: rtl/oma_agen.sv
module oma_agen #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] areg,
  input  logic [AW-1:0] offs,
  input  logic [2:0]    mode,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nxt,
  output logic          wen
);
  import oma_pkg::*;

  always_comb begin
    ea  = areg;
    nxt = areg;
    wen = 1'b0;
    case (mode)
      UM_INC:    begin nxt = areg + 1'b1; wen = 1'b1; end
      UM_DEC:    begin nxt = areg - 1'b1; wen = 1'b1; end
      UM_ADDN:   begin nxt = areg + offs; wen = 1'b1; end
      UM_SUBN:   begin nxt = areg - offs; wen = 1'b1; end
      UM_INDEX:  ea = areg + offs;
      UM_PREDEC: begin ea = areg - 1'b1; nxt = areg - 1'b1; wen = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/oma_areg_file.sv
module oma_areg_file #(
  parameter int AW   = 6,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] rsel_a,
  input  logic [SW-1:0] rsel_b,
  output logic [AW-1:0] rdat_a,
  output logic [AW-1:0] rdat_b,
  input  logic          we_a,
  input  logic [SW-1:0] wsel_a,
  input  logic [AW-1:0] wdat_a,
  input  logic          we_b,
  input  logic [SW-1:0] wsel_b,
  input  logic [AW-1:0] wdat_b
);
  logic [AW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (we_a && wsel_a == SW'(i))
        regs[i] <= wdat_a;
      else if (we_b && wsel_b == SW'(i))
        regs[i] <= wdat_b;
    end
  end

  assign rdat_a = regs[rsel_a];
  assign rdat_b = regs[rsel_b];
endmodule

// File: rtl/oma_bank.sv
module oma_bank #(
  parameter int DW    = 32,
  parameter int AW    = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we)
        mem[addr] <= wd;
      else
        q <= mem[addr];
    end
  end
endmodule

// File: rtl/oma_unit.sv
module oma_unit #(
  parameter int DW   = 32,
  parameter int AW   = 6,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    ref_kind,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_b,
  input  logic [2:0]    upd_a,
  input  logic [2:0]    upd_b,
  input  logic [AW-1:0] offs,
  input  logic          bank_a,
  input  logic          bank_b,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata_a,
  input  logic [DW-1:0] wdata_b,
  output logic [AW-1:0] x_addr,
  output logic          x_en,
  output logic          x_we,
  output logic [DW-1:0] x_wdata,
  output logic [AW-1:0] y_addr,
  output logic          y_en,
  output logic          y_we,
  output logic [DW-1:0] y_wdata,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [1:0]    rd_vld,
  output logic          err
);
  import oma_pkg::*;

  localparam int NLANE = 2;

  // ---------------- address registers and generators ----------------
  logic [AW-1:0] areg_v [NLANE];
  logic [AW-1:0] ea     [NLANE];
  logic [AW-1:0] nxt    [NLANE];
  logic          upd_en [NLANE];
  logic [2:0]    mode   [NLANE];

  assign mode[0] = upd_a;
  assign mode[1] = upd_b;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    oma_agen #(.AW(AW)) u_agen (
      .areg (areg_v[l]),
      .offs (offs),
      .mode (mode[l]),
      .ea   (ea[l]),
      .nxt  (nxt[l]),
      .wen  (upd_en[l])
    );
  end

  // ---------------- request decode and legality ----------------
  logic is_x, is_y, is_long, is_dual, is_comm;
  logic dual_ok, single_ok, legal, go;

  always_comb begin
    is_x    = ref_kind == RK_XWORD;
    is_y    = ref_kind == RK_YWORD;
    is_long = ref_kind == RK_LONG;
    is_dual = ref_kind == RK_DUAL;
    is_comm = ref_kind == RK_COMMON;
    dual_ok = (sel_a[SW-1] != sel_b[SW-1]) && (bank_a != bank_b) &&
              (upd_a <= UM_DUAL_MAX) && (upd_b <= UM_DUAL_MAX);
    single_ok = (is_x || is_y || is_long || is_comm) && (upd_a != UM_BAD);
    legal   = is_dual ? dual_ok : single_ok;
    go      = req_valid && legal;
  end

  logic we_upd_a, we_upd_b;
  assign we_upd_a = go && upd_en[0];
  assign we_upd_b = go && is_dual && upd_en[1];

  oma_areg_file #(.AW(AW), .NREG(NREG)) u_aregs (
    .clk    (clk),
    .rst    (rst),
    .rsel_a (sel_a),
    .rsel_b (sel_b),
    .rdat_a (areg_v[0]),
    .rdat_b (areg_v[1]),
    .we_a   (we_upd_a),
    .wsel_a (sel_a),
    .wdat_a (nxt[0]),
    .we_b   (we_upd_b),
    .wsel_b (sel_b),
    .wdat_b (nxt[1])
  );

  // ---------------- bank command formation ----------------
  logic          x_go_n, y_go_n;
  logic          x_use_b, y_addr_b, y_data_b;
  logic [AW-1:0] x_addr_n, y_addr_n;
  logic          x_we_n, y_we_n;
  logic [DW-1:0] x_wd_n, y_wd_n;

  always_comb begin
    x_go_n   = go && (is_x || is_long || is_comm || is_dual);
    y_go_n   = go && (is_y || is_long || is_comm || is_dual);
    // independent dual: operand B goes to whichever bank A does not use
    x_use_b  = is_dual && bank_a;
    y_addr_b = is_dual && !bank_a;
    y_data_b = is_long || is_comm || y_addr_b;
    x_addr_n = x_use_b ? ea[1]   : ea[0];
    x_we_n   = x_use_b ? wr_b    : wr_a;
    x_wd_n   = x_use_b ? wdata_b : wdata_a;
    y_addr_n = y_addr_b ? ea[1]  : ea[0];
    y_we_n   = y_addr_b ? wr_b   : wr_a;
    y_wd_n   = y_data_b ? wdata_b : wdata_a;
  end

  // stage 1: registered bank commands
  logic x_lane1, y_lane1;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_en    <= 1'b0;
      y_en    <= 1'b0;
      x_we    <= 1'b0;
      y_we    <= 1'b0;
      x_addr  <= '0;
      y_addr  <= '0;
      x_wdata <= '0;
      y_wdata <= '0;
      x_lane1 <= 1'b0;
      y_lane1 <= 1'b0;
      err     <= 1'b0;
    end else begin
      x_en    <= x_go_n;
      y_en    <= y_go_n;
      x_we    <= x_we_n;
      y_we    <= y_we_n;
      x_addr  <= x_addr_n;
      y_addr  <= y_addr_n;
      x_wdata <= x_wd_n;
      y_wdata <= y_wd_n;
      x_lane1 <= x_use_b;
      y_lane1 <= y_data_b;
      err     <= req_valid && !legal;
    end
  end

  // ---------------- banks ----------------
  logic [DW-1:0] qx, qy;

  oma_bank #(.DW(DW), .AW(AW)) u_bank_x (
    .clk  (clk),
    .en   (x_en),
    .we   (x_we),
    .addr (x_addr),
    .wd   (x_wdata),
    .q    (qx)
  );

  oma_bank #(.DW(DW), .AW(AW)) u_bank_y (
    .clk  (clk),
    .en   (y_en),
    .we   (y_we),
    .addr (y_addr),
    .wd   (y_wdata),
    .q    (qy)
  );

  // stage 2: read return tracking
  logic rv_x, rv_y, x_lane2, y_lane2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_x    <= 1'b0;
      rv_y    <= 1'b0;
      x_lane2 <= 1'b0;
      y_lane2 <= 1'b0;
    end else begin
      rv_x    <= x_en && !x_we;
      rv_y    <= y_en && !y_we;
      x_lane2 <= x_lane1;
      y_lane2 <= y_lane1;
    end
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    if (rv_x && !x_lane2) rd_a = qx;
    else if (rv_y && !y_lane2) rd_a = qy;
    if (rv_x && x_lane2) rd_b = qx;
    else if (rv_y && y_lane2) rd_b = qy;
    rd_vld[0] = (rv_x && !x_lane2) || (rv_y && !y_lane2);
    rd_vld[1] = (rv_x && x_lane2) || (rv_y && y_lane2);
  end
endmodule

// File: rtl/oma_unit_chk.sv
module oma_unit_chk #(
  parameter int AW = 6,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    ref_kind,
  input logic [SW-1:0] sel_a,
  input logic [SW-1:0] sel_b,
  input logic [2:0]    upd_a,
  input logic [2:0]    upd_b,
  input logic          bank_a,
  input logic          bank_b,
  input logic [AW-1:0] x_addr,
  input logic          x_en,
  input logic          x_we,
  input logic [AW-1:0] y_addr,
  input logic          y_en,
  input logic          y_we,
  input logic [1:0]    rd_vld,
  input logic          err
);
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> (!x_en && !y_en));

  p_pair_group_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ref_kind == 3'd3 && sel_a[SW-1] == sel_b[SW-1]) |=> err);

  p_pair_bank_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ref_kind == 3'd3 && bank_a == bank_b) |=> err);

  p_dual_mode_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ref_kind == 3'd3 && (upd_a > 3'd3 || upd_b > 3'd3)) |=> err);

  p_long_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ref_kind == 3'd2 && upd_a != 3'd7) |=>
      (x_en && y_en && x_addr == y_addr));

  p_common_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ref_kind == 3'd4 && upd_a != 3'd7) |=>
      (x_en && y_en && x_addr == y_addr && x_we == y_we));

  p_read_return_r9: assert property (@(posedge clk) disable iff (rst)
    ((x_en && !x_we) || (y_en && !y_we)) |=> (rd_vld != 2'b00));

  p_no_read_r9: assert property (@(posedge clk) disable iff (rst)
    (!(x_en && !x_we) && !(y_en && !y_we)) |=> (rd_vld == 2'b00));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!x_en && !y_en && !err));
endmodule

bind oma_unit oma_unit_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .ref_kind  (ref_kind),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .upd_a     (upd_a),
  .upd_b     (upd_b),
  .bank_a    (bank_a),
  .bank_b    (bank_b),
  .x_addr    (x_addr),
  .x_en      (x_en),
  .x_we      (x_we),
  .y_addr    (y_addr),
  .y_en      (y_en),
  .y_we      (y_we),
  .rd_vld    (rd_vld),
  .err       (err)
);

// File: tb/oma_unit_bench.sv
`timescale 1ns/1ps
module oma_unit_bench;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [2:0]    ref_kind;
  logic [2:0]    sel_a, sel_b, upd_a, upd_b;
  logic [AW-1:0] offs;
  logic          bank_a, bank_b, wr_a, wr_b;
  logic [DW-1:0] wdata_a, wdata_b;
  logic [AW-1:0] x_addr, y_addr;
  logic          x_en, x_we, y_en, y_we, err;
  logic [DW-1:0] x_wdata, y_wdata, rd_a, rd_b;
  logic [1:0]    rd_vld;

  always #2.5 clk = ~clk;

  oma_unit #(.DW(DW), .AW(AW), .NREG(8)) u_oma_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ref_kind(ref_kind),
    .sel_a(sel_a), .sel_b(sel_b), .upd_a(upd_a), .upd_b(upd_b), .offs(offs),
    .bank_a(bank_a), .bank_b(bank_b), .wr_a(wr_a), .wr_b(wr_b),
    .wdata_a(wdata_a), .wdata_b(wdata_b),
    .x_addr(x_addr), .x_en(x_en), .x_we(x_we), .x_wdata(x_wdata),
    .y_addr(y_addr), .y_en(y_en), .y_we(y_we), .y_wdata(y_wdata),
    .rd_a(rd_a), .rd_b(rd_b), .rd_vld(rd_vld), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [AW-1:0] m_areg [8];
  logic [DW-1:0] m_x [DEPTH];
  logic [DW-1:0] m_y [DEPTH];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] f_ea(input logic [AW-1:0] r, input logic [AW-1:0] n,
                                         input logic [2:0] m);
    if (m == 3'd5) return r + n;
    if (m == 3'd6) return r - 1'b1;
    return r;
  endfunction

  function automatic logic [AW-1:0] f_nx(input logic [AW-1:0] r, input logic [AW-1:0] n,
                                         input logic [2:0] m);
    case (m)
      3'd1: return r + 1'b1;
      3'd2: return r - 1'b1;
      3'd3: return r + n;
      3'd4: return r - n;
      3'd6: return r - 1'b1;
      default: return r;
    endcase
  endfunction

  function automatic bit f_upd(input logic [2:0] m);
    return (m >= 3'd1 && m <= 3'd4) || m == 3'd6;
  endfunction

  function automatic logic [DW-1:0] px(input int a);
    return 32'hC0DE_0000 | DW'(a * 7);
  endfunction

  function automatic logic [DW-1:0] py(input int a);
    return 32'h5EED_0000 | DW'(a * 13);
  endfunction

  // one request, checked at both result points
  task automatic req(input logic [2:0] k, input logic [2:0] sa, input logic [2:0] sb,
                     input logic [2:0] ua, input logic [2:0] ub,
                     input bit ba, input bit bb, input bit wa, input bit wb,
                     input logic [DW-1:0] da, input logic [DW-1:0] db,
                     input logic [AW-1:0] n, input string tag);
    logic [AW-1:0] eaa, eab, xa, ya;
    bit legal, d, xen, yen, xb, yab, ydb, xwe, ywe, va, vb;
    logic [DW-1:0] xwd, ywd, rx, ry, ea_rd, eb_rd;
    eaa = f_ea(m_areg[sa], n, ua);
    eab = f_ea(m_areg[sb], n, ub);
    d = (k == 3'd3);
    legal = d ? (sa[2] != sb[2] && ba != bb && ua <= 3'd3 && ub <= 3'd3)
              : (k <= 3'd4 && ua != 3'd7);
    xen = legal && k != 3'd1;
    yen = legal && k != 3'd0;
    xb  = d && ba;
    yab = d && !ba;
    ydb = (k == 3'd2) || (k == 3'd4) || yab;
    xa  = xb ? eab : eaa;
    xwe = xb ? wb : wa;
    xwd = xb ? db : da;
    ya  = yab ? eab : eaa;
    ywe = yab ? wb : wa;
    ywd = ydb ? db : da;

    @(negedge clk);
    req_valid = 1'b1; ref_kind = k; sel_a = sa; sel_b = sb; upd_a = ua; upd_b = ub;
    bank_a = ba; bank_b = bb; wr_a = wa; wr_b = wb; wdata_a = da; wdata_b = db; offs = n;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == !legal, legal ? tag : "R10", "err", 64'(err), 64'(!legal));
    chk(x_en == xen, tag, "x_en", 64'(x_en), 64'(xen));
    chk(y_en == yen, tag, "y_en", 64'(y_en), 64'(yen));
    if (xen) begin
      chk(x_addr == xa, tag, "x_addr", 64'(x_addr), 64'(xa));
      chk(x_we == xwe, tag, "x_we", 64'(x_we), 64'(xwe));
      if (xwe) chk(x_wdata == xwd, tag, "x_wdata", 64'(x_wdata), 64'(xwd));
    end
    if (yen) begin
      chk(y_addr == ya, tag, "y_addr", 64'(y_addr), 64'(ya));
      chk(y_we == ywe, tag, "y_we", 64'(y_we), 64'(ywe));
      if (ywe) chk(y_wdata == ywd, tag, "y_wdata", 64'(y_wdata), 64'(ywd));
    end
    // model update
    rx = m_x[xa];
    ry = m_y[ya];
    if (xen && xwe) m_x[xa] = xwd;
    if (yen && ywe) m_y[ya] = ywd;
    if (legal && f_upd(ua)) m_areg[sa] = f_nx(m_areg[sa], n, ua);
    if (legal && d && f_upd(ub)) m_areg[sb] = f_nx(m_areg[sb], n, ub);
    va = (xen && !xwe && !xb) || (yen && !ywe && !ydb);
    vb = (xen && !xwe && xb) || (yen && !ywe && ydb);
    ea_rd = (xen && !xwe && !xb) ? rx : ry;
    eb_rd = (xen && !xwe && xb) ? rx : ry;
    @(posedge clk);
    @(negedge clk);
    chk(rd_vld == {vb, va}, "R9", "rd_vld", 64'(rd_vld), 64'({vb, va}));
    if (va) chk(rd_a == ea_rd, tag, "rd_a", 64'(rd_a), 64'(ea_rd));
    if (vb) chk(rd_b == eb_rd, tag, "rd_b", 64'(rd_b), 64'(eb_rd));
    chk(!x_en && !y_en && !err, "R11", "idle enables", 64'({x_en, y_en, err}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_areg[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin m_x[i] = '0; m_y[i] = '0; end
    rst = 1'b1; req_valid = 1'b0; ref_kind = '0; sel_a = '0; sel_b = '0;
    upd_a = '0; upd_b = '0; offs = '0; bank_a = 1'b0; bank_b = 1'b0;
    wr_a = 1'b0; wr_b = 1'b0; wdata_a = '0; wdata_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk(!x_en && !y_en && !err && rd_vld == 2'b00, "R11", "reset outputs",
        64'({x_en, y_en, err, rd_vld}), 64'd0);

    // R1 / R7: fill X with post-increment on register 0
    for (int a = 0; a < DEPTH; a++)
      req(3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 0, 0, 1, 0, px(a), '0, '0, "R1");
    // R1 / R7: fill Y with post-decrement on register 4 (0, 63, 62, ...)
    for (int a = 0; a < DEPTH; a++)
      req(3'd1, 3'd4, 3'd0, 3'd2, 3'd0, 0, 0, 1, 0, py((DEPTH - a) % DEPTH), '0, '0, "R1");
    // R1: single-word reads from each bank
    for (int a = 0; a < 8; a++) begin
      req(3'd0, 3'd3, 3'd0, 3'd3, 3'd0, 0, 0, 0, 0, '0, '0, 6'd5, "R1");
      req(3'd1, 3'd6, 3'd0, 3'd4, 3'd0, 0, 0, 0, 0, '0, '0, 6'd3, "R1");
    end
    // R2: long-word reads over every address
    for (int a = 0; a < DEPTH; a++)
      req(3'd2, 3'd2, 3'd0, 3'd1, 3'd0, 0, 0, 0, 0, '0, '0, '0, "R2");
    // R2 / R7: long-word writes with indexed address, then read back
    for (int a = 0; a < 8; a++) begin
      req(3'd2, 3'd2, 3'd0, 3'd5, 3'd0, 0, 0, 1, 0, 32'hAAAA_0000 + a, 32'h5555_0000 + a,
          6'(a * 9), "R2");
      req(3'd2, 3'd2, 3'd0, 3'd5, 3'd0, 0, 0, 0, 0, '0, '0, 6'(a * 9), "R2");
    end
    // R3 / R8: independent dual, all four allowed modes, mixed directions and banks
    for (int i = 0; i < 64; i++)
      req(3'd3, 3'(i % 4), 3'(4 + (i / 4) % 4), 3'(i % 4), 3'((i / 4) % 4),
          i[4], !i[4], i[5], i[3], 32'hD000_0000 + i, 32'hE000_0000 + i, 6'(i * 5 + 1), "R3");
    // R6 / R7: common dual across every update mode and both directions
    for (int m = 0; m < 7; m++) begin
      req(3'd4, 3'(m), 3'd0, 3'(m), 3'd0, 0, 0, 1, 0, 32'hF000_0000 + m, 32'h0F00_0000 + m,
          6'd11, "R6");
      req(3'd4, 3'(m), 3'd0, 3'(m), 3'd0, 0, 0, 0, 0, '0, '0, 6'd11, "R7");
    end
    // R4: same group, then same bank; followed by probes of the untouched registers
    req(3'd3, 3'd1, 3'd2, 3'd1, 3'd1, 0, 1, 1, 1, 32'h1, 32'h2, '0, "R4");
    req(3'd3, 3'd5, 3'd7, 3'd1, 3'd1, 0, 1, 0, 0, '0, '0, '0, "R4");
    req(3'd3, 3'd1, 3'd5, 3'd1, 3'd1, 1, 1, 0, 0, '0, '0, '0, "R4");
    req(3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, '0, '0, '0, "R4");
    req(3'd1, 3'd5, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, '0, '0, '0, "R4");
    // R5: disallowed dual update modes on either operand
    for (int m = 4; m < 8; m++) begin
      req(3'd3, 3'd0, 3'd4, 3'(m), 3'd0, 0, 1, 0, 0, '0, '0, 6'd2, "R5");
      req(3'd3, 3'd0, 3'd4, 3'd0, 3'(m), 0, 1, 0, 0, '0, '0, 6'd2, "R5");
    end
    // R6: illegal kinds and mode 7
    for (int k = 5; k < 8; k++)
      req(3'(k), 3'd0, 3'd0, 3'd1, 3'd0, 0, 0, 1, 0, 32'hBAD0, '0, '0, "R6");
    req(3'd4, 3'd2, 3'd0, 3'd7, 3'd0, 0, 0, 1, 0, 32'hBAD1, 32'hBAD2, '0, "R6");
    req(3'd2, 3'd2, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, '0, '0, '0, "R10");
    // R8: back-to-back use of an updated register
    req(3'd0, 3'd0, 3'd0, 3'd3, 3'd0, 0, 0, 0, 0, '0, '0, 6'd17, "R8");
    req(3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, '0, '0, '0, "R8");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule